// File: doc/BRIEF.md
# Tuner Synthesizer Serial Control Slave

This block is a two-wire serial slave that sits between a host bus and the frequency synthesizer of a broadcast tuner. It samples the clock and data lines with the chip's system clock, and it recognises its own 7-bit address, whose two low bits come from a pin-strapped select input. A write carries either one or two pairs of data bytes. The top bit of the first byte of each pair tells the block which kind of pair it is. A divider pair sets the 15-bit division ratio. A control pair sets the pump, test, step and drive bits, followed by the band-port bits.

A read returns a status byte. That byte carries a sticky power-on flag, the lock indication from the loop, and a flag that tells whether the charge pump has fallen back to its automatic low current. The power-on flag clears once the host has read it. The supply monitor can set it again.

Top module: `tuner_i2c_ctrl`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal binary 11000 followed by `addr_sel_i[1]` and `addr_sel_i[0]`. The eighth bit of that byte selects a write when it is 0 and a read when it is 1.
- R2: In a write to this block, the slave pulls SDA low in the acknowledge slot after every data byte.
- R3: The top bit of the first byte of each pair selects the pair type: 0 for divider and 1 for control. Transfers of 2 or 4 data bytes are accepted, and the two pair types may come in either order.
- R4: The first divider byte carries bits 14..8 of the divider in its low seven bits, and the second divider byte carries bits 7..0. `div_o` changes only when the second byte completes, and it never changes after the first byte alone.
- R5: The control byte's low seven bits land on `ctrl_o` as {CP, T2, T1, T0, step A, step B, drive-off}, bit 6 down to bit 0. The control byte, and then the band byte, each take effect on the eighth SCL rise of that byte. `band_o` takes the band byte's low four bits {UHF, FM/test, VHF-high, VHF-low}, and the band byte's upper four bits have no effect.
- R6: After reset, `div_o` is 0, `ctrl_o` is 7'h57 (CP=1, T2=0, T1=1, T0=0, both step bits 1, drive-off 1), `band_o` is 0 and `sda_oe_o` is 0.
- R7: The status byte is {POR, lock_i, ACPS, 00000}, bit 7 down to bit 0. ACPS is 0 when CP=1 and `lock_i`=1, and 1 otherwise.
- R8: POR is 1 after reset and after any cycle with `supply_low_i` high. It becomes 0 once a status byte has been shifted out.
- R9: A START or STOP before a divider pair is complete discards the held first divider byte, so a later single byte cannot combine with it.
- R10: When the master acknowledges a status byte, another status byte follows. When the master does not acknowledge it, the slave releases SDA and waits for STOP or START.
- R11: After a non-matching address the block gives no acknowledge and ignores every byte up to the next START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least ten times the bus rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| addr_sel_i | input | 2 | Programmable low address bits |
| lock_i | input | 1 | Synthesizer lock indication |
| supply_low_i | input | 1 | Supply monitor low indication |
| div_o | output | 15 | Division ratio |
| ctrl_o | output | 7 | Control bits {CP,T2,T1,T0,stepA,stepB,drive-off} |
| band_o | output | 4 | Band port bits {UHF,FM/test,VHF-high,VHF-low} |

## Verification
A table of writes drives the register path. It covers divider-then-control, control-then-divider, a lone divider pair and a lone control pair, so a fault in pair-type decoding, pair ordering or byte-count handling changes the final register values. Band bytes with non-zero upper nibbles show whether those bits leak into the port outputs. Directed transfers separate the moment of divider commit from a mid-pair abort, and a wrong address from a re-strapped one. Read sequences with different lock, CP and supply-monitor states tell the POR, lock and ACPS bits apart, and they also show whether reading clears the power-on flag.

// File: rtl/tuner_i2c_pkg.sv
package tuner_i2c_pkg;
    localparam int BYTE_W = 8;
    localparam int DIV_W  = 15;
    localparam int HI_W   = DIV_W - BYTE_W;
    localparam int CNT_W  = $clog2(BYTE_W);
    localparam logic [4:0] ADDR_FIXED = 5'b11000;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_ACK, ST_WRITE, ST_READ, ST_RD_ACK, ST_WAIT
    } bus_st_t;

    typedef struct packed {
        logic cp;
        logic t2;
        logic t1;
        logic t0;
        logic step_a;
        logic step_b;
        logic drv_off;
    } ctrl_t;

    typedef struct packed {
        logic uhf;
        logic fm_test;
        logic vhf_hi;
        logic vhf_lo;
    } band_t;

    localparam ctrl_t CTRL_RST = '{cp: 1'b1, t2: 1'b0, t1: 1'b1, t0: 1'b0,
                                   step_a: 1'b1, step_b: 1'b1, drv_off: 1'b1};

    function automatic logic addr_hit(input logic [6:0] a, input logic [1:0] sel);
        return a == {ADDR_FIXED, sel};
    endfunction

    function automatic logic [BYTE_W-1:0] status_word(input logic por, input logic lock,
                                                      input logic cp);
        return {por, lock, ~(cp & lock), 5'b00000};
    endfunction
endpackage

// File: rtl/tuner_i2c_line_sync.sv
module tuner_i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic [STAGES:0] scl_sh, sda_sh;
    logic scl_now, scl_prev, sda_now, sda_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh <= '1;
            sda_sh <= '1;
        end else begin
            scl_sh <= {scl_sh[STAGES-1:0], scl_i};
            sda_sh <= {sda_sh[STAGES-1:0], sda_i};
        end
    end

    assign scl_now  = scl_sh[STAGES-1];
    assign scl_prev = scl_sh[STAGES];
    assign sda_now  = sda_sh[STAGES-1];
    assign sda_prev = sda_sh[STAGES];

    assign sda_o      = sda_now;
    assign scl_rise_o = scl_now & ~scl_prev;
    assign scl_fall_o = ~scl_now & scl_prev;
    assign start_o    = scl_now & scl_prev & sda_prev & ~sda_now;
    assign stop_o     = scl_now & scl_prev & ~sda_prev & sda_now;
endmodule

// File: rtl/tuner_i2c_byte_engine.sv
module tuner_i2c_byte_engine
    import tuner_i2c_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              sda_i,
    input  logic [1:0]        addr_sel_i,
    input  logic [BYTE_W-1:0] status_i,
    output logic              sda_oe_o,
    output logic              byte_valid_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic              abort_o,
    output logic              rd_done_o
);
    bus_st_t            st;
    logic [CNT_W-1:0]   bitcnt;
    logic [BYTE_W-1:0]  shreg, byte_q;
    logic               ack_phase, is_read, mack_q;
    logic               sda_oe_q, byte_valid_q, rd_done_q, abort_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_IDLE;
            bitcnt <= '0;
            shreg <= '0;
            byte_q <= '0;
            ack_phase <= 1'b0;
            is_read <= 1'b0;
            mack_q <= 1'b0;
            sda_oe_q <= 1'b0;
            byte_valid_q <= 1'b0;
            rd_done_q <= 1'b0;
            abort_q <= 1'b0;
        end else begin
            byte_valid_q <= 1'b0;
            rd_done_q <= 1'b0;
            abort_q <= 1'b0;
            if (start_i) begin
                st <= ST_ADDR;
                bitcnt <= '0;
                ack_phase <= 1'b0;
                sda_oe_q <= 1'b0;
                abort_q <= 1'b1;
            end else if (stop_i) begin
                st <= ST_IDLE;
                ack_phase <= 1'b0;
                sda_oe_q <= 1'b0;
                abort_q <= 1'b1;
            end else begin
                case (st)
                    ST_ADDR, ST_WRITE: if (scl_rise_i) begin
                        shreg <= {shreg[BYTE_W-2:0], sda_i};
                        bitcnt <= bitcnt + 1'b1;
                        if (bitcnt == CNT_W'(BYTE_W - 1)) begin
                            bitcnt <= '0;
                            if (st == ST_ADDR) begin
                                if (addr_hit(shreg[6:0], addr_sel_i)) begin
                                    st <= ST_ACK;
                                    is_read <= sda_i;
                                end else begin
                                    st <= ST_WAIT;
                                end
                            end else begin
                                byte_valid_q <= 1'b1;
                                byte_q <= {shreg[BYTE_W-2:0], sda_i};
                                st <= ST_ACK;
                            end
                        end
                    end
                    ST_ACK: if (scl_fall_i) begin
                        if (!ack_phase) begin
                            ack_phase <= 1'b1;
                            sda_oe_q <= 1'b1;
                        end else begin
                            ack_phase <= 1'b0;
                            bitcnt <= '0;
                            if (is_read) begin
                                st <= ST_READ;
                                shreg <= status_i;
                                sda_oe_q <= ~status_i[BYTE_W-1];
                            end else begin
                                st <= ST_WRITE;
                                sda_oe_q <= 1'b0;
                            end
                        end
                    end
                    ST_READ: if (scl_fall_i) begin
                        if (bitcnt == CNT_W'(BYTE_W - 1)) begin
                            st <= ST_RD_ACK;
                            sda_oe_q <= 1'b0;
                            rd_done_q <= 1'b1;
                            mack_q <= 1'b0;
                            bitcnt <= '0;
                        end else begin
                            shreg <= {shreg[BYTE_W-2:0], 1'b0};
                            sda_oe_q <= ~shreg[BYTE_W-2];
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise_i) mack_q <= ~sda_i;
                        if (scl_fall_i) begin
                            if (mack_q) begin
                                st <= ST_READ;
                                shreg <= status_i;
                                sda_oe_q <= ~status_i[BYTE_W-1];
                            end else begin
                                st <= ST_WAIT;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_oe_o     = sda_oe_q;
    assign byte_valid_o = byte_valid_q;
    assign byte_o       = byte_q;
    assign abort_o      = abort_q;
    assign rd_done_o    = rd_done_q;

    // R2: the line is only ever pulled low just after SCL has gone low
    assert_drive_after_fall_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe_q) |-> $past(scl_fall_i));
    // R3: a received byte is reported only after an SCL rise
    assert_byte_on_rise_R3: assert property (@(posedge clk) disable iff (rst)
        byte_valid_q |-> $past(scl_rise_i));
    // R10: while waiting for STOP the slave keeps the line released
    assert_nack_release_R10: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WAIT) |-> !sda_oe_q);
endmodule

// File: rtl/tuner_reg_bank.sv
module tuner_reg_bank
    import tuner_i2c_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_valid_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              abort_i,
    input  logic              rd_done_i,
    input  logic              supply_low_i,
    output logic [DIV_W-1:0]  div_o,
    output ctrl_t             ctrl_o,
    output band_t             band_o,
    output logic              por_o
);
    logic [DIV_W-1:0] div_q;
    logic [HI_W-1:0]  div_hi;
    ctrl_t            ctrl_q;
    band_t            band_q;
    logic             mid_pair, pair_is_ctl, por_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
            div_hi <= '0;
            ctrl_q <= CTRL_RST;
            band_q <= '0;
            mid_pair <= 1'b0;
            pair_is_ctl <= 1'b0;
        end else if (abort_i) begin
            mid_pair <= 1'b0;
        end else if (byte_valid_i) begin
            if (!mid_pair) begin
                mid_pair <= 1'b1;
                pair_is_ctl <= byte_i[BYTE_W-1];
                if (byte_i[BYTE_W-1]) ctrl_q <= ctrl_t'(byte_i[6:0]);
                else                  div_hi <= byte_i[HI_W-1:0];
            end else begin
                mid_pair <= 1'b0;
                if (pair_is_ctl) band_q <= band_t'(byte_i[3:0]);
                else             div_q <= {div_hi, byte_i};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)               por_q <= 1'b1;
        else if (supply_low_i) por_q <= 1'b1;
        else if (rd_done_i)    por_q <= 1'b0;
    end

    assign div_o  = div_q;
    assign ctrl_o = ctrl_q;
    assign band_o = band_q;
    assign por_o  = por_q;

    // R4: the divider moves only when the second byte of a divider pair lands
    assert_div_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !(byte_valid_i && mid_pair && !pair_is_ctl && !abort_i) |=> $stable(div_q));
    // R5: control bits move only on a completed byte
    assert_ctrl_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !byte_valid_i |=> $stable(ctrl_q));
    // R8: the power-on flag drops only after a status byte went out
    assert_por_clear_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(por_q) |-> $past(rd_done_i));
endmodule

// File: rtl/tuner_i2c_ctrl.sv
module tuner_i2c_ctrl
    import tuner_i2c_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe_o,
    input  logic [1:0]       addr_sel_i,
    input  logic             lock_i,
    input  logic             supply_low_i,
    output logic [DIV_W-1:0] div_o,
    output logic [6:0]       ctrl_o,
    output logic [3:0]       band_o
);
    logic sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    logic byte_valid, abort, rd_done, por;
    logic [BYTE_W-1:0] rx_byte, status;
    ctrl_t ctrl_w;
    band_t band_w;

    tuner_i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .sda_o(sda_s),
        .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
        .start_o(start_ev), .stop_o(stop_ev)
    );

    assign status = status_word(por, lock_i, ctrl_w.cp);

    tuner_i2c_byte_engine u_eng (
        .clk(clk), .rst(rst), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
        .start_i(start_ev), .stop_i(stop_ev), .sda_i(sda_s),
        .addr_sel_i(addr_sel_i), .status_i(status), .sda_oe_o(sda_oe_o),
        .byte_valid_o(byte_valid), .byte_o(rx_byte), .abort_o(abort),
        .rd_done_o(rd_done)
    );

    tuner_reg_bank u_regs (
        .clk(clk), .rst(rst), .byte_valid_i(byte_valid), .byte_i(rx_byte),
        .abort_i(abort), .rd_done_i(rd_done), .supply_low_i(supply_low_i),
        .div_o(div_o), .ctrl_o(ctrl_w), .band_o(band_w), .por_o(por)
    );

    assign ctrl_o = ctrl_w;
    assign band_o = band_w;
endmodule

// File: tb/tb_tuner_i2c_ctrl.sv
module tb_tuner_i2c_ctrl;
    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic [1:0] addr_sel = 2'b10;
    logic lock = 1'b0, supply_low = 1'b0;
    logic sda_oe;
    logic [14:0] div;
    logic [6:0] ctrl;
    logic [3:0] band;
    wire sda_bus = sda_m & ~sda_oe;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    tuner_i2c_ctrl dut (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe_o(sda_oe),
        .addr_sel_i(addr_sel), .lock_i(lock), .supply_low_i(supply_low),
        .div_o(div), .ctrl_o(ctrl), .band_o(band)
    );

    typedef struct packed {
        logic [2:0]  n;
        logic [7:0]  b0, b1, b2, b3;
        logic [14:0] div;
        logic [6:0]  ctl;
        logic [3:0]  band;
    } vec_t;

    // R3 R4 R5: pair order, byte count, band upper nibble ignored
    localparam vec_t VEC [5] = '{
        '{3'd4, 8'h0C, 8'hA0, 8'h8E, 8'h31, 15'h0CA0, 7'h0E, 4'h1},
        '{3'd4, 8'hC8, 8'hF6, 8'h7F, 8'hFF, 15'h7FFF, 7'h48, 4'h6},
        '{3'd2, 8'h04, 8'h00, 8'h00, 8'h00, 15'h0400, 7'h48, 4'h6},
        '{3'd2, 8'hFF, 8'h0F, 8'h00, 8'h00, 15'h0400, 7'h7F, 4'hF},
        '{3'd4, 8'h00, 8'h01, 8'h81, 8'hA9, 15'h0001, 7'h01, 4'h9}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wq;
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; wq; scl_m = 1'b1; wq; sda_m = 1'b0; wq; scl_m = 1'b0; wq;
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; wq; scl_m = 1'b1; wq; sda_m = 1'b1; wq;
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; wq; scl_m = 1'b1; wq; wq; scl_m = 1'b0; wq;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; wq; scl_m = 1'b1; wq;
        ack = ~sda_bus;
        wq; scl_m = 1'b0; wq;
    endtask

    task automatic read_byte(output logic [7:0] b, input logic mack);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq; scl_m = 1'b1; wq; b[i] = sda_bus; wq; scl_m = 1'b0;
        end
        wq; sda_m = ~mack; wq; scl_m = 1'b1; wq; wq; scl_m = 1'b0; wq; sda_m = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic ack;
        logic [7:0] rb;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        chk("R6 div", 32'(div), 32'h0);
        chk("R6 ctrl", 32'(ctrl), 32'h57);
        chk("R6 band", 32'(band), 32'h0);
        chk("R6 sda", 32'(sda_oe), 32'h0);

        // R7 R8: first read after reset, unlocked, CP=1
        bus_start; send_byte(8'hC5, ack);
        chk("R1 read addr ack", 32'(ack), 32'h1);
        read_byte(rb, 1'b0);
        chk("R7 R8 status por", 32'(rb), 32'hA0);
        bus_stop;
        chk("R10 release after nack", 32'(sda_oe), 32'h0);

        // R10: master ack gives second status byte; POR now clear, locked
        lock = 1'b1;
        bus_start; send_byte(8'hC5, ack);
        read_byte(rb, 1'b1);
        chk("R8 por cleared", 32'(rb), 32'h40);
        read_byte(rb, 1'b0);
        chk("R10 repeat status", 32'(rb), 32'h40);
        bus_stop;

        for (int v = 0; v < 5; v++) begin
            bus_start; send_byte(8'hC4, ack);
            chk("R1 write addr ack", 32'(ack), 32'h1);
            send_byte(VEC[v].b0, ack); chk("R2 ack b0", 32'(ack), 32'h1);
            send_byte(VEC[v].b1, ack); chk("R2 ack b1", 32'(ack), 32'h1);
            if (VEC[v].n == 3'd4) begin
                send_byte(VEC[v].b2, ack); chk("R2 ack b2", 32'(ack), 32'h1);
                send_byte(VEC[v].b3, ack); chk("R2 ack b3", 32'(ack), 32'h1);
            end
            bus_stop;
            chk("R3 R4 div", 32'(div), 32'(VEC[v].div));
            chk("R3 R5 ctrl", 32'(ctrl), 32'(VEC[v].ctl));
            chk("R5 band", 32'(band), 32'(VEC[v].band));
        end

        // R4: commit only on the second divider byte
        bus_start; send_byte(8'hC4, ack);
        send_byte(8'h12, ack);
        chk("R4 no commit after first", 32'(div), 32'h0001);
        send_byte(8'h34, ack);
        chk("R4 commit after second", 32'(div), 32'h1234);
        bus_stop;

        // R9: STOP after a lone high byte, then repeated START mid-pair
        bus_start; send_byte(8'hC4, ack); send_byte(8'h55, ack); bus_stop;
        chk("R9 stop discards", 32'(div), 32'h1234);
        bus_start; send_byte(8'hC4, ack); send_byte(8'h2A, ack);
        bus_start; send_byte(8'hC4, ack); send_byte(8'h03, ack); send_byte(8'h21, ack);
        bus_stop;
        chk("R9 restart discards", 32'(div), 32'h0321);
        bus_start; send_byte(8'hC4, ack); send_byte(8'h11, ack);
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        bus_start; bus_stop;
        chk("R9 mid-byte abort", 32'(div), 32'h0321);

        // R11: wrong address ignored
        bus_start; send_byte(8'hC0, ack);
        chk("R11 no ack", 32'(ack), 32'h0);
        send_byte(8'h00, ack);
        chk("R11 no data ack", 32'(ack), 32'h0);
        send_byte(8'h05, ack);
        bus_stop;
        chk("R11 div kept", 32'(div), 32'h0321);

        // R1: re-strapped select makes the same address match
        addr_sel = 2'b00;
        bus_start; send_byte(8'hC0, ack);
        chk("R1 new select ack", 32'(ack), 32'h1);
        send_byte(8'h00, ack); send_byte(8'h05, ack);
        bus_stop;
        chk("R1 new select write", 32'(div), 32'h0005);

        // R8 R7: supply-low sets POR again; CP=0 so ACPS=1 while locked
        supply_low = 1'b1; repeat (3) @(negedge clk); supply_low = 1'b0;
        bus_start; send_byte(8'hC1, ack);
        read_byte(rb, 1'b0);
        bus_stop;
        chk("R8 R7 por after supply low", 32'(rb), 32'hE0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule